// File: doc/BRIEF.md
# Page-Mode DRAM Start-up and Cycle Sequencer

This block is the timing engine that sits between a simple host port and an asynchronous page-mode DRAM array. It generates the row strobe, column strobe, write enable and a shared row/column address bus. Every minimum strobe width and gap is a whole number of system clocks, derived at elaboration from the speed grade and the clock period.

After reset the array sees no strobe activity for a long power-up pause. Then a fixed run of refresh cycles is issued. A parameter selects whether these start-up refreshes are row-only (an internal row counter on the address bus) or column-before-row (the array counts rows itself). The host is ignored until the last start-up refresh has finished.

After that, the sequencer serves one read or one write per host request and acknowledges each with a single-clock pulse. A refresh timer raises a periodic column-before-row refresh request. That request wins over a waiting host request but never cuts short a cycle that has already started.

Top module: `dram_seq`

## Requirements
- R1: From reset and for at least 200 µs of clocks (20000 cycles at the default 10 ns period), ras_n, cas_n and we_n stay high and dq_oe stays low. The first row-strobe fall comes no later than 5 cycles after the pause ends.
- R2: With INIT_CBR=0, the first 8 row-strobe pulses after the pause are row-only refreshes. cas_n is high at each fall, and dram_addr carries rows 0,1,...,7 in that order.
- R3: With INIT_CBR=1, each of the first 8 row-strobe falls finds cas_n already low in the preceding cycle.
- R4: No ack is given before the 8 start-up refreshes have completed, even if req is held from reset.
- R5: Every row-strobe low time is at least ceil(tRAS/clk) cycles (6 for the -60 grade) and below ceil(10 µs/clk) cycles.
- R6: Between pulses, the row strobe stays high for at least ceil(tRP/clk) cycles (4). Consecutive row-strobe falls are at least ceil(tRC/clk) cycles apart (11).
- R7: dram_addr holds the row for at least one cycle before the row strobe falls. It holds the column for at least one cycle before the column strobe falls during an access. addr[2*AW-1:AW] is the row and addr[AW-1:0] is the column.
- R8: For a read (we=0), ack is high for exactly one cycle. rdata then equals the array data sampled at the end of the column-strobe low phase.
- R9: For a write (we=1), we_n is low and dq_oe is high with dq_o = wdata at the column-strobe fall. During reads, dq_oe is low at that fall. Written data reads back unchanged.
- R10: After start-up, a column-before-row refresh is issued at least once every 15.6 µs plus one access. This holds even under back-to-back host requests, and no access is lost or corrupted.
- R11: The column strobe stays high for at least one cycle between any two low phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2*AW | Row in upper half, column in lower half |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid with ack |
| ack | output | 1 | One-cycle completion pulse |
| dram_addr | output | AW | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_o | output | DW | Data toward the array |
| dq_oe | output | 1 | Drive enable for dq_o |
| dq_i | input | DW | Data from the array |

## Verification
The periodic refresh timer and a pending host request can both be ready in the same idle cycle. The bench provokes this by keeping the host busy with several hundred back-to-back reads across multiple refresh periods, so the timer inevitably expires while a request is already waiting. The result is judged at the pins: the gap between column-before-row refreshes must stay within one refresh interval plus one access, and every read in the run must still return the stored value with a single ack.

// File: rtl/dseq_pkg.sv
package dseq_pkg;

    typedef enum logic [3:0] {
        ST_PAUSE,
        ST_IDLE,
        ST_ASU,
        ST_ROW,
        ST_COL,
        ST_CASL,
        ST_ROR,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_PRE
    } seq_st_e;

    typedef enum logic [1:0] {
        JOB_RD,
        JOB_WR,
        JOB_REF
    } job_e;

    function automatic int cyc_of(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // grade 0 = 60 ns part, grade 1 = 70 ns part
    function automatic int grade_trc(input int g);
        return (g != 0) ? 130 : 110;
    endfunction

    function automatic int grade_trp(input int g);
        return (g != 0) ? 50 : 40;
    endfunction

    function automatic int grade_tras(input int g);
        return (g != 0) ? 70 : 60;
    endfunction

    function automatic int grade_trah(input int g);
        return (g != 0) ? 10 : 10;
    endfunction

endpackage

// File: rtl/dseq_dncnt.sv
module dseq_dncnt #(
    parameter int W       = 16,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/dseq_reftmr.sv
module dseq_reftmr #(
    parameter int PERIOD = 1560
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    output logic pend
);
    localparam int TW = $clog2(PERIOD + 1);

    logic [TW-1:0] tcnt;
    logic          wrap;

    assign wrap = (tcnt == TW'(PERIOD - 1));

    always_ff @(posedge clk) begin
        if (rst || !en)
            tcnt <= '0;
        else if (wrap)
            tcnt <= '0;
        else
            tcnt <= tcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (en && wrap)
            pend <= 1'b1;
        else if (clr)
            pend <= 1'b0;
    end

    // a raised refresh request survives until the sequencer takes it
    assert_pend_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);
endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dseq_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int GRADE     = 0,
    parameter int PAUSE_NS  = 200000,
    parameter int REFI_NS   = 15600,
    parameter int RASMAX_NS = 10000,
    parameter int RDHOLD_NS = 17,
    parameter int N_INIT    = 8,
    parameter bit INIT_CBR  = 1'b0,
    parameter int AW        = 11,
    parameter int DW        = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req,
    input  logic            we,
    input  logic [2*AW-1:0] addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            ack,
    output logic [AW-1:0]   dram_addr,
    output logic            ras_n,
    output logic            cas_n,
    output logic            we_n,
    output logic [DW-1:0]   dq_o,
    output logic            dq_oe,
    input  logic [DW-1:0]   dq_i
);
    localparam int T_PAUSE_C  = cyc_of(PAUSE_NS, CLK_NS);
    localparam int T_RAS_C    = cyc_of(grade_tras(GRADE), CLK_NS);
    localparam int T_RP_C     = cyc_of(grade_trp(GRADE), CLK_NS);
    localparam int T_RC_C     = cyc_of(grade_trc(GRADE), CLK_NS);
    localparam int T_RAH_C    = imax(1, cyc_of(grade_trah(GRADE), CLK_NS));
    localparam int T_RDW_C    = imax(1, cyc_of(RDHOLD_NS, CLK_NS));
    localparam int T_REFI_C   = cyc_of(REFI_NS, CLK_NS);
    localparam int T_RASMAX_C = cyc_of(RASMAX_NS, CLK_NS);
    localparam int T_CASL_C   = imax(T_RDW_C, T_RAS_C - T_RAH_C - 1);
    localparam int T_LOW_C    = T_RAH_C + 1 + T_CASL_C;
    // row strobe is high for T_PRE_C plus an idle and a setup cycle
    localparam int T_PRE_C    = imax(1, imax(T_RP_C - 2, T_RC_C - T_LOW_C - 2));
    localparam int CW         = $clog2(imax(T_PAUSE_C, imax(T_LOW_C, T_PRE_C)) + 1);
    localparam int IW         = $clog2(N_INIT + 1);
    localparam int SAT        = T_RASMAX_C + T_RC_C;
    localparam int SW         = $clog2(SAT + 1);

    typedef struct packed {
        job_e          kind;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        logic [DW-1:0] wdata;
    } job_t;

    seq_st_e       st, nxt;
    job_t          job, job_n;
    logic          done, load;
    logic [CW-1:0] lval;
    logic [IW-1:0] init_left;
    logic [AW-1:0] ref_row;
    logic          init_busy, ref_pend, ref_clr;
    logic          start_acc, start_ref, ref_end, wr_phase;

    assign init_busy = (init_left != '0);
    assign ref_end   = (st == ST_ROR || st == ST_CBR_RAS) && done;

    function automatic int dur_of(input seq_st_e s);
        case (s)
            ST_PAUSE:              return T_PAUSE_C;
            ST_ROW:                return T_RAH_C;
            ST_CASL:               return T_CASL_C;
            ST_ROR, ST_CBR_RAS:    return T_LOW_C;
            ST_PRE:                return T_PRE_C;
            default:               return 1;
        endcase
    endfunction

    dseq_dncnt #(.W(CW), .RST_VAL(T_PAUSE_C - 1)) u_dly (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .val  (lval),
        .done (done)
    );

    dseq_reftmr #(.PERIOD(T_REFI_C)) u_ref (
        .clk  (clk),
        .rst  (rst),
        .en   (!init_busy),
        .clr  (ref_clr),
        .pend (ref_pend)
    );

    always_comb begin
        nxt       = st;
        start_acc = 1'b0;
        start_ref = 1'b0;
        case (st)
            ST_PAUSE: if (done) nxt = ST_IDLE;
            ST_IDLE: begin
                if (init_busy) begin
                    nxt       = INIT_CBR ? ST_CBR_CAS : ST_ASU;
                    start_ref = 1'b1;
                end else if (ref_pend) begin
                    nxt       = ST_CBR_CAS;
                    start_ref = 1'b1;
                end else if (req) begin
                    nxt       = ST_ASU;
                    start_acc = 1'b1;
                end
            end
            ST_ASU:     nxt = (job.kind == JOB_REF) ? ST_ROR : ST_ROW;
            ST_ROW:     if (done) nxt = ST_COL;
            ST_COL:     nxt = ST_CASL;
            ST_CASL:    if (done) nxt = ST_PRE;
            ST_ROR:     if (done) nxt = ST_PRE;
            ST_CBR_CAS: nxt = ST_CBR_RAS;
            ST_CBR_RAS: if (done) nxt = ST_PRE;
            ST_PRE:     if (done) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    assign load    = (nxt != st);
    assign lval    = CW'(dur_of(nxt) - 1);
    assign ref_clr = !init_busy && (st == ST_IDLE) && (nxt == ST_CBR_CAS);

    always_comb begin
        job_n = job;
        if (start_acc) begin
            job_n.kind  = we ? JOB_WR : JOB_RD;
            job_n.row   = addr[2*AW-1:AW];
            job_n.col   = addr[AW-1:0];
            job_n.wdata = wdata;
        end else if (start_ref) begin
            job_n.kind = JOB_REF;
            job_n.row  = ref_row;
        end
    end

    assign wr_phase = (job_n.kind == JOB_WR) && (nxt inside {ST_COL, ST_CASL});

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_PAUSE;
            job       <= '0;
            init_left <= IW'(N_INIT);
            ref_row   <= '0;
        end else begin
            st  <= nxt;
            job <= job_n;
            if (ref_end && init_busy)
                init_left <= init_left - 1'b1;
            if (st == ST_ROR && done)
                ref_row <= ref_row + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_n     <= 1'b1;
            cas_n     <= 1'b1;
            we_n      <= 1'b1;
            dq_oe     <= 1'b0;
            dq_o      <= '0;
            dram_addr <= '0;
            ack       <= 1'b0;
            rdata     <= '0;
        end else begin
            ras_n <= !(nxt inside {ST_ROW, ST_COL, ST_CASL, ST_ROR, ST_CBR_RAS});
            cas_n <= !(nxt inside {ST_CASL, ST_CBR_CAS, ST_CBR_RAS});
            we_n  <= !wr_phase;
            dq_oe <= wr_phase;
            dq_o  <= job_n.wdata;
            if (nxt inside {ST_ASU, ST_ROW, ST_ROR})
                dram_addr <= job_n.row;
            else if (nxt inside {ST_COL, ST_CASL})
                dram_addr <= job_n.col;
            ack <= (st == ST_CASL) && done;
            if (st == ST_CASL && done && job.kind == JOB_RD)
                rdata <= dq_i;
        end
    end

    // strobe run-length counters used only by the checks below
    logic [SW-1:0] ras_lo, ras_hi, since_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_lo     <= '0;
            ras_hi     <= '0;
            since_fall <= SW'(SAT);
        end else begin
            ras_lo     <= ras_n ? '0 : ((ras_lo == SW'(SAT)) ? ras_lo : ras_lo + 1'b1);
            ras_hi     <= !ras_n ? '0 : ((ras_hi == SW'(SAT)) ? ras_hi : ras_hi + 1'b1);
            since_fall <= (!ras_n && ras_lo == '0) ? SW'(1)
                        : ((since_fall == SW'(SAT)) ? since_fall : since_fall + 1'b1);
        end
    end

    assert_quiet_pause_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAUSE) |-> (ras_n && cas_n && we_n && !dq_oe));

    assert_cbr_order_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

    assert_no_early_ack_R4: assert property (@(posedge clk) disable iff (rst)
        init_busy |-> !ack);

    assert_ras_min_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> (ras_lo >= SW'(T_RAS_C)));

    assert_ras_max_R5: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> (ras_lo < SW'(T_RASMAX_C)));

    assert_ras_pre_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (ras_hi >= SW'(T_RP_C)));

    assert_ras_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (since_fall >= SW'(T_RC_C)));

    assert_row_setup_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $stable(dram_addr));

    assert_col_setup_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(cas_n) && !ras_n) |-> $stable(dram_addr));

    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack);

    assert_cas_gap_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(cas_n) |=> cas_n);
endmodule

// File: tb/sim_dram_seq.sv
module sim_dram_seq;
    localparam int EXP_PAUSE  = 200000 / 10;
    localparam int EXP_RAS    = 6;
    localparam int EXP_RP     = 4;
    localparam int EXP_RC     = 11;
    localparam int EXP_REFI   = 1560;
    localparam int EXP_RASMAX = 1000;

    typedef struct packed {
        logic        we;
        logic [10:0] row;
        logic [10:0] col;
        logic [15:0] data;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b1, 11'd1, 11'd2, 16'hA5A5},
        '{1'b1, 11'd2, 11'd1, 16'h3C3C},
        '{1'b0, 11'd1, 11'd2, 16'hA5A5},
        '{1'b1, 11'd3, 11'd3, 16'hFFFF},
        '{1'b0, 11'd2, 11'd1, 16'h3C3C},
        '{1'b0, 11'd3, 11'd3, 16'hFFFF},
        '{1'b1, 11'd1, 11'd2, 16'h0001},
        '{1'b0, 11'd1, 11'd2, 16'h0001},
        '{1'b0, 11'd0, 11'd0, 16'h0000}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, req, we;
    logic [21:0] addr;
    logic [15:0] wdata, rdata, dq_o, dq_i;
    logic        ack, ras_n, cas_n, we_n, dq_oe;
    logic [10:0] dram_addr;

    logic [15:0] r1_rdata, r1_dq_o;
    logic        r1_ack, r1_ras_n, r1_cas_n, r1_we_n, r1_dq_oe;
    logic [10:0] r1_addr;

    dram_seq u0 (
        .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ack(ack), .dram_addr(dram_addr), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i)
    );

    dram_seq #(.INIT_CBR(1'b1)) u1 (
        .clk(clk), .rst(rst), .req(1'b0), .we(1'b0), .addr(22'd0), .wdata(16'd0),
        .rdata(r1_rdata), .ack(r1_ack), .dram_addr(r1_addr), .ras_n(r1_ras_n),
        .cas_n(r1_cas_n), .we_n(r1_we_n), .dq_o(r1_dq_o), .dq_oe(r1_dq_oe),
        .dq_i(16'd0)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // array model and pin monitor, all sampled on the falling clock edge
    logic [15:0] mem [16];
    logic [1:0]  row_lat, col_lat;
    assign dq_i = mem[{row_lat, col_lat}];

    int  cyc = 0, n_fall = 0, first_fall = -1, early_ack = 0, oe_bad = 0;
    int  lo_cnt = 0, hi_cnt = 0, since = 0, cas_hi = 0, n_casf = 0;
    int  min_lo = 1 << 30, max_lo = 0, min_hi = 1 << 30, min_rc = 1 << 30, min_cas_hi = 1 << 30;
    int  n_cbr = 0, last_cbr = -1, max_gap = 0;
    int  init_row [8];
    bit  init_cas [8];
    bit  prev_ras = 1'b1, prev_cas = 1'b1;
    int  n1_fall = 0;
    bit  init1_ok [8];
    bit  prev1_ras = 1'b1, prev1_cas = 1'b1;

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        row_lat = '0;
        col_lat = '0;
    end

    always @(negedge clk) begin
        if (!rst) begin
            cyc++;
            if (prev_ras && !ras_n) begin
                n_fall++;
                row_lat = dram_addr[1:0];
                if (n_fall <= 8) begin
                    init_row[n_fall-1] = int'(dram_addr);
                    init_cas[n_fall-1] = cas_n;
                end
                if (n_fall == 1) first_fall = cyc;
                if (n_fall > 1 && hi_cnt < min_hi) min_hi = hi_cnt;
                if (n_fall > 1 && since < min_rc) min_rc = since;
                since = 0;
                if (!cas_n && n_fall > 8) begin
                    n_cbr++;
                    if (last_cbr >= 0 && cyc - last_cbr > max_gap) max_gap = cyc - last_cbr;
                    last_cbr = cyc;
                end
            end
            if (!prev_ras && ras_n) begin
                if (lo_cnt < min_lo) min_lo = lo_cnt;
                if (lo_cnt > max_lo) max_lo = lo_cnt;
            end
            if (prev_cas && !cas_n) begin
                if (n_casf > 0 && cas_hi < min_cas_hi) min_cas_hi = cas_hi;
                n_casf++;
                if (!ras_n) begin
                    col_lat = dram_addr[1:0];
                    if (!we_n) begin
                        mem[{row_lat, col_lat}] = dq_o;
                        if (!dq_oe) oe_bad++;
                    end else if (dq_oe) begin
                        oe_bad++;
                    end
                end
            end
            if (ack && n_fall < 8) early_ack++;
            if (ras_n) begin hi_cnt++; lo_cnt = 0; end
            else begin lo_cnt++; hi_cnt = 0; end
            if (cas_n) cas_hi++; else cas_hi = 0;
            since++;
            prev_ras = ras_n;
            prev_cas = cas_n;

            if (prev1_ras && !r1_ras_n) begin
                n1_fall++;
                if (n1_fall <= 8) init1_ok[n1_fall-1] = !r1_cas_n && !prev1_cas;
            end
            prev1_ras = r1_ras_n;
            prev1_cas = r1_cas_n;
        end
    end

    task automatic do_req(input vec_t v, output logic [15:0] rd, output bit got, output bit ack_after);
        req   = 1'b1;
        we    = v.we;
        addr  = {v.row, v.col};
        wdata = v.data;
        got   = 1'b0;
        rd    = '0;
        for (int i = 0; i < 40000 && !got; i++) begin
            @(negedge clk);
            if (ack) begin
                got = 1'b1;
                rd  = rdata;
            end
        end
        req = 1'b0;
        @(negedge clk);
        ack_after = ack;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        bit got, ack_after;
        int bad;
        rst = 1'b1; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        repeat (4) @(negedge clk);
        chk(ras_n && cas_n && we_n && !dq_oe && !ack, "R1 reset strobes",
            {ras_n, cas_n, we_n, dq_oe, ack}, 5'b11100);
        rst = 1'b0;

        // vector table: writes followed by readbacks, first one held from reset
        foreach (VEC[i]) begin
            do_req(VEC[i], rd, got, ack_after);
            chk(got, "R8 ack arrives", got, 1);
            chk(!ack_after, "R8 ack one cycle", ack_after, 0);
            if (i == 0)
                chk(n_fall >= 9 && early_ack == 0, "R4 host held off during start-up",
                    n_fall, 9);
            if (!VEC[i].we)
                chk(rd == VEC[i].data, "R7 R8 R9 readback", rd, VEC[i].data);
        end

        // directed: start-up pause and refresh style
        chk(first_fall >= EXP_PAUSE && first_fall <= EXP_PAUSE + 5,
            "R1 quiet pause length", first_fall, EXP_PAUSE);
        for (int i = 0; i < 8; i++) begin
            chk(init_row[i] == i && init_cas[i], "R2 row-only start-up refresh",
                init_row[i], i);
            chk(init1_ok[i], "R3 column-first start-up refresh", init1_ok[i], 1);
        end

        // refresh against a constantly waiting host
        bad = 0;
        for (int k = 0; k < 320; k++) begin
            do_req('{1'b0, 11'd1, 11'd2, 16'h0001}, rd, got, ack_after);
            if (!got || rd != 16'h0001 || ack_after) bad++;
        end
        chk(bad == 0, "R10 accesses intact across refresh", bad, 0);
        chk(n_cbr >= 2, "R10 periodic refresh issued", n_cbr, 2);
        chk(max_gap <= EXP_REFI + 20, "R10 refresh interval", max_gap, EXP_REFI);

        // strobe timing collected by the monitor
        chk(min_lo >= EXP_RAS, "R5 row strobe low minimum", min_lo, EXP_RAS);
        chk(max_lo < EXP_RASMAX, "R5 row strobe low maximum", max_lo, EXP_RASMAX);
        chk(min_hi >= EXP_RP, "R6 row precharge", min_hi, EXP_RP);
        chk(min_rc >= EXP_RC, "R6 row cycle", min_rc, EXP_RC);
        chk(oe_bad == 0, "R9 data drive at column fall", oe_bad, 0);
        chk(min_cas_hi >= 1, "R11 column precharge", min_cas_hi, 1);

        summary();
        $finish;
    end
endmodule